// File: doc/BRIEF.md
# Radix-4 Booth Multiplier with Signed-Zero Weight

This block multiplies two unsigned k-bit operands and returns the full 2k-bit product one clock after a start strobe. The second operand (the multiplier) is recoded into radix-4 signed digits, one digit for each pair of bits plus one extra top digit for unsigned range. The recoder keeps a negative zero digit apart from a positive zero digit. A negative zero is built as an all-ones row plus a correction bit, just as any other negative digit is built.

Each digit selects a multiple of the multiplicand: 0, 1x or 2x, complemented when the digit is negative. All rows, plus one row that carries every correction bit, go into a carry-save tree of 3-to-2 counters. The tree ends in a single carry-propagate adder.

Beside the product, the block reports a Booth weight for the multiplier operand. Each +0 digit scores 0, each -0 digit scores 2 and each other digit scores 1. A caller can use this count to study how the activity of the partial-product array depends on the data.

Top module: `booth_mult`

## Requirements
- R1: With ext = {zero-extension, mplier, 1'b0}, digit i is taken from the triplet ext[2i+2:2i], which is mplier bits 2i+1, 2i, 2i-1 with bit -1 equal to 0. There are K/2+1 digits, and the top digit reads zero-extended bits above bit K-1.
- R2: The triplet maps to a digit as follows: 000 gives +0 and 111 gives -0; 001 and 010 give +1; 011 gives +2; 100 gives -2; 101 and 110 give -1. The -0 digit stays distinct from +0.
- R3: The product output equals mcand*mplier for all unsigned operand values, taken over 2K bits.
- R4: booth_wt is the sum over all digits of 0 for +0, 2 for -0 and 1 for any of ±1 or ±2. It never exceeds 2*(K/2+1).
- R5: product, booth_wt and valid are registered. valid is high in exactly the cycle after a cycle with start high, and low otherwise.
- R6: While start stays low, product and booth_wt keep their last values.
- R7: Synchronous active-high reset clears product, booth_wt and valid at the next clock edge.
- R8: The operand width K is a parameter. Both K=8 and K=16 produce correct products and weights.
- R9: A zero multiplicand yields a zero product for every multiplier value. The weight still follows the multiplier's digits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Captures the operands this cycle |
| mcand | input | K | Multiplicand |
| mplier | input | K | Multiplier (Booth-recoded operand) |
| product | output | 2K | Registered product |
| valid | output | 1 | Pulses one cycle after start |
| booth_wt | output | WW | Registered Booth weight of mplier, WW = clog2(2*(K/2+1)+1) |

## Verification
At K=8, every pair of operands is applied back to back, so every triplet in every digit position appears alongside every multiplicand. This separates a wrong recoding entry from a wrong row construction or a missing correction bit. A K=16 instance runs random operands in the same cycles, which shows that the parameterised tree depth and digit count scale. Directed cases follow: all-ones multipliers, which give runs of -0 and are the only thing that tells -0 apart from +0 in the weight; a set top bit, which exercises the extra zero-extended digit; a zero multiplicand; and reset and idle cycles, which show that the outputs clear and hold.

// File: rtl/booth_pkg.sv
package booth_pkg;
  // One recoded radix-4 digit: sign plus magnitude select.
  // neg=1 with one=0,two=0 is the negative zero digit.
  typedef struct packed {
    logic neg;
    logic one;
    logic two;
  } bdigit_t;

  function automatic int unsigned digit_score(bdigit_t d);
    if (!d.one && !d.two) return d.neg ? 2 : 0;
    return 1;
  endfunction
endpackage

// File: rtl/booth_recoder.sv
module booth_recoder
  import booth_pkg::*;
#(
  parameter int K  = 8,
  parameter int ND = K/2 + 1,
  parameter int WW = $clog2(2*ND + 1)
) (
  input  logic [K-1:0]           mplier,
  output bdigit_t [ND-1:0]       dig,
  output logic [WW-1:0]          wt
);
  localparam int EW = 2*ND + 1;

  logic [EW-1:0] ext;
  assign ext = {{(EW-K-1){1'b0}}, mplier, 1'b0};

  for (genvar i = 0; i < ND; i++) begin : g_dig
    logic [2:0] trip;
    assign trip = ext[2*i+2 -: 3];
    always_comb begin
      unique case (trip)
        3'b000: dig[i] = '{neg:1'b0, one:1'b0, two:1'b0};
        3'b001,
        3'b010: dig[i] = '{neg:1'b0, one:1'b1, two:1'b0};
        3'b011: dig[i] = '{neg:1'b0, one:1'b0, two:1'b1};
        3'b100: dig[i] = '{neg:1'b1, one:1'b0, two:1'b1};
        3'b101,
        3'b110: dig[i] = '{neg:1'b1, one:1'b1, two:1'b0};
        default: dig[i] = '{neg:1'b1, one:1'b0, two:1'b0};
      endcase
    end
  end

  always_comb begin
    int unsigned acc;
    acc = 0;
    for (int i = 0; i < ND; i++) acc += digit_score(dig[i]);
    wt = WW'(acc);
  end
endmodule

// File: rtl/booth_ppgen.sv
module booth_ppgen
  import booth_pkg::*;
#(
  parameter int K  = 8,
  parameter int ND = K/2 + 1,
  parameter int W  = 2*K,
  parameter int NR = ND + 1
) (
  input  logic [K-1:0]          mcand,
  input  bdigit_t [ND-1:0]      dig,
  output logic [NR-1:0][W-1:0]  rows
);
  // One row per digit; the last row gathers the +1 corrections
  // of all negative digits (positions 2i never collide).
  for (genvar i = 0; i < ND; i++) begin : g_row
    logic [K:0]   mag;
    logic [W-1:0] wide;
    always_comb begin
      if (dig[i].two)      mag = {mcand, 1'b0};
      else if (dig[i].one) mag = {1'b0, mcand};
      else                 mag = '0;
      wide = W'(mag);
      if (dig[i].neg) wide = ~wide;
    end
    assign rows[i] = wide << (2*i);
  end

  always_comb begin
    rows[ND] = '0;
    for (int i = 0; i < ND; i++) rows[ND][2*i] = dig[i].neg;
  end
endmodule

// File: rtl/booth_csa_tree.sv
module booth_csa_tree #(
  parameter int W  = 16,
  parameter int NR = 6
) (
  input  logic [NR-1:0][W-1:0] rows,
  output logic [W-1:0]         sum_o,
  output logic [W-1:0]         carry_o
);
  // Level-by-level 3-to-2 reduction: each level compresses every
  // complete triple and passes leftover rows straight down.
  always_comb begin
    logic [W-1:0] cur [NR];
    logic [W-1:0] nxt [NR];
    int n;
    int m;
    for (int j = 0; j < NR; j++) cur[j] = rows[j];
    n = NR;
    for (int lvl = 0; lvl < NR; lvl++) begin
      for (int j = 0; j < NR; j++) nxt[j] = '0;
      m = 0;
      if (n > 2) begin
        for (int j = 0; j + 2 < NR; j += 3) begin
          if (j + 2 < n) begin
            nxt[m]   = cur[j] ^ cur[j+1] ^ cur[j+2];
            nxt[m+1] = ((cur[j] & cur[j+1]) | (cur[j] & cur[j+2]) |
                        (cur[j+1] & cur[j+2])) << 1;
            m += 2;
          end
        end
        for (int j = 0; j < NR; j++) begin
          if (j >= (n/3)*3 && j < n) begin
            nxt[m] = cur[j];
            m += 1;
          end
        end
        for (int j = 0; j < NR; j++) cur[j] = nxt[j];
        n = m;
      end
    end
    sum_o   = cur[0];
    carry_o = (n > 1) ? cur[1] : '0;
  end
endmodule

// File: rtl/booth_cpa.sv
module booth_cpa #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] s
);
  assign s = a + b;
endmodule

// File: rtl/booth_mult.sv
module booth_mult
  import booth_pkg::*;
#(
  parameter int K = 8,
  localparam int ND = K/2 + 1,
  localparam int WW = $clog2(2*ND + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [K-1:0]    mcand,
  input  logic [K-1:0]    mplier,
  output logic [2*K-1:0]  product,
  output logic            valid,
  output logic [WW-1:0]   booth_wt
);
  localparam int W  = 2*K;
  localparam int NR = ND + 1;

  bdigit_t [ND-1:0]     dig;
  logic [WW-1:0]        wt_c;
  logic [NR-1:0][W-1:0] rows;
  logic [W-1:0]         cs_sum, cs_car, prod_c;

  booth_recoder #(.K(K), .ND(ND), .WW(WW)) u_rec (
    .mplier(mplier), .dig(dig), .wt(wt_c));

  booth_ppgen #(.K(K), .ND(ND), .W(W), .NR(NR)) u_pp (
    .mcand(mcand), .dig(dig), .rows(rows));

  booth_csa_tree #(.W(W), .NR(NR)) u_tree (
    .rows(rows), .sum_o(cs_sum), .carry_o(cs_car));

  booth_cpa #(.W(W)) u_cpa (
    .a(cs_sum), .b(cs_car), .s(prod_c));

  always_ff @(posedge clk) begin
    if (rst) begin
      product  <= '0;
      booth_wt <= '0;
      valid    <= 1'b0;
    end else begin
      valid <= start;
      if (start) begin
        product  <= prod_c;
        booth_wt <= wt_c;
      end
    end
  end

  AST_VALID_AFTER_START: assert property (@(posedge clk) disable iff (rst)
    start |=> valid);                                            // R5
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
    !start |=> !valid);                                          // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !start |=> ($stable(product) && $stable(booth_wt)));         // R6
  AST_ZERO_MCAND: assert property (@(posedge clk) disable iff (rst)
    (start && mcand == '0) |=> (product == '0));                 // R9
  AST_WT_BOUND: assert property (@(posedge clk) disable iff (rst)
    valid |-> (int'(booth_wt) <= 2*ND));                         // R4
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!valid && product == '0 && booth_wt == '0));        // R7
endmodule

// File: tb/tb_booth_mult.sv
module tb_booth_mult;
  localparam int PERIOD = 10;
  localparam int WA = 4;  // weight width for K=8
  localparam int WB = 5;  // weight width for K=16

  typedef struct {
    logic [15:0] p;
    int          w;
    string       tag;
  } exp8_t;
  typedef struct {
    logic [31:0] p;
    int          w;
    string       tag;
  } exp16_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [7:0]  a8 = '0, b8 = '0;
  logic [15:0] a16 = '0, b16 = '0;
  logic [15:0] p8;
  logic [31:0] p16;
  logic v8, v16;
  logic [WA-1:0] w8;
  logic [WB-1:0] w16;

  int checks = 0;
  int fails  = 0;
  exp8_t  q8[$];
  exp16_t q16[$];

  always #(PERIOD/2) clk = ~clk;

  booth_mult #(.K(8)) dut (
    .clk(clk), .rst(rst), .start(start), .mcand(a8), .mplier(b8),
    .product(p8), .valid(v8), .booth_wt(w8));

  booth_mult #(.K(16)) dut_w16 (
    .clk(clk), .rst(rst), .start(start), .mcand(a16), .mplier(b16),
    .product(p16), .valid(v16), .booth_wt(w16));

  // Behavioural weight from the triplet table (R1, R2, R4)
  function automatic int ref_wt(logic [15:0] b, int k);
    int s = 0;
    for (int i = 0; i <= k/2; i++) begin
      logic [2:0] t;
      t[2] = (2*i+1 < k) ? b[2*i+1] : 1'b0;
      t[1] = (2*i   < k) ? b[2*i]   : 1'b0;
      t[0] = (i > 0 && 2*i-1 < k) ? b[2*i-1] : 1'b0;
      if (t == 3'b000)      s += 0;
      else if (t == 3'b111) s += 2;
      else                  s += 1;
    end
    return s;
  endfunction

  task automatic drive(input logic [7:0] xa, input logic [7:0] xb,
                       input logic [15:0] ya, input logic [15:0] yb,
                       input string tag);
    exp8_t  e8;
    exp16_t e16;
    @(negedge clk);
    a8 = xa; b8 = xb; a16 = ya; b16 = yb; start = 1'b1;
    e8.p = 16'(xa) * 16'(xb);   e8.w = ref_wt(16'(xb), 8);  e8.tag = tag;
    e16.p = 32'(ya) * 32'(yb);  e16.w = ref_wt(yb, 16);     e16.tag = tag;
    q8.push_back(e8);
    q16.push_back(e16);
  endtask

  // Monitor: compare each result against the head of the queues
  always @(posedge clk) begin
    #1;
    if (!rst) begin
      if (v8) begin
        checks++;
        if (q8.size() == 0) begin
          fails++;
          $display("FAIL R5 K=8 unexpected valid: actual 1 expected 0");
        end else begin
          exp8_t e;
          e = q8.pop_front();
          if (p8 !== e.p || int'(w8) != e.w) begin
            fails++;
            $display("FAIL %s K=8 a=%0d b=%0d: actual p=%0d w=%0d expected p=%0d w=%0d",
                     e.tag, a8, b8, p8, w8, e.p, e.w);
          end
        end
      end
      if (v16) begin
        checks++;
        if (q16.size() == 0) begin
          fails++;
          $display("FAIL R5 K=16 unexpected valid: actual 1 expected 0");
        end else begin
          exp16_t e;
          e = q16.pop_front();
          if (p16 !== e.p || int'(w16) != e.w) begin
            fails++;
            $display("FAIL %s R8 K=16: actual p=%0h w=%0d expected p=%0h w=%0d",
                     e.tag, p16, w16, e.p, e.w);
          end
        end
      end
    end
  end

  task automatic check(input bit ok, input string req,
                       input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R7 reset state
    check(p8 == 0 && w8 == 0 && v8 == 0, "R7 reset state K=8",
          longint'(p8) + w8 + v8, 0);
    check(p16 == 0 && w16 == 0 && v16 == 0, "R7 reset state K=16",
          longint'(p16) + w16 + v16, 0);

    // Directed corners
    drive(8'hFF, 8'hFF, 16'hFFFF, 16'hFFFF, "R2 negzero runs");
    drive(8'h5A, 8'h00, 16'h1234, 16'h0000, "R2 poszero only");
    drive(8'h00, 8'hAB, 16'h0000, 16'hBEEF, "R9 zero mcand");
    drive(8'h01, 8'h80, 16'h0001, 16'h8000, "R1 top digit");
    drive(8'hC3, 8'hFE, 16'hA5A5, 16'hFFFE, "R1 R2 mixed digits");
    drive(8'hFF, 8'h55, 16'hFFFF, 16'h5555, "R2 plus one digits");

    // Exhaustive K=8 with random K=16 alongside (R3 R4 R8)
    for (int i = 0; i < 256; i++)
      for (int j = 0; j < 256; j++)
        drive(8'(i), 8'(j), 16'($urandom), 16'($urandom), "R3 R4 R8");

    @(negedge clk);
    start = 1'b0;
    a8 = 8'h77; b8 = 8'h99; a16 = 16'h1111; b16 = 16'h2222;
    repeat (3) @(negedge clk);
    // R6: last vector was 255*255 with weight of 0xFF
    check(p8 == 16'd65025 && int'(w8) == ref_wt(16'h00FF, 8) && !v8,
          "R6 hold while idle", p8, 65025);
    check(q8.size() == 0 && q16.size() == 0, "R5 all results delivered",
          q8.size() + q16.size(), 0);

    // R7 reset mid-stream clears registered outputs
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(p8 == 0 && w8 == 0 && !v8, "R7 reset clears K=8",
          longint'(p8) + w8, 0);
    check(p16 == 0 && w16 == 0 && !v16, "R7 reset clears K=16",
          longint'(p16) + w16, 0);
    finish_run();
  end
endmodule